// File: doc/BRIEF.md
# Prescaled Wakeup Timer

This block is a wakeup timer for an always-on clock domain. Software sets a start value in a count register and a compare value in a threshold register. It then turns the timer on through a control register that also holds a prescale divisor. While the timer is on, the count steps up by one every prescale+1 clocks. Once the count is above the threshold, a wake event latches a sticky status bit, and that bit drives the interrupt pin.

Software can also change the status directly. A write-one-to-clear register clears it, a write-one-to-set test register sets it, and a cause register loads it with the value written. The interrupt has no separate enable: it is active whenever the timer is on.

Every write to the control, count or threshold register restarts the prescale phase. A written value reaches the counting logic two clock edges after the write edge.

Top module: `wakeup_timer`

## Requirements
- R1: After an active-low reset, every readable register reads 0 and `irqWake` is low.
- R2: Software can read back the registers it writes. Address 0 holds the enable in bit 0 and the 12-bit prescale value in bits 12:1. Address 2 holds the 32-bit threshold. Address 1 returns the live 32-bit count.
- R3: Take a count c no greater than the threshold t, a prescale p, and an enable write at edge E0. `irqWake` rises after edge E0 + (t−c+1)(p+1) + 2 and is low after the edge before it.
- R4: If the count is already above the threshold when the timer is enabled, `irqWake` rises after the second edge following the enable write.
- R5: The count steps by one every p+1 clocks while the timer is enabled. Read D ≥ 1 edges after the enable write edge, it equals c + ⌊(D−1)/(p+1)⌋.
- R6: While the enable bit is clear, the count holds its value.
- R7: The interrupt status is sticky. It stays set after a wake event, even once the timer is disabled.
- R8: Writing 1 to bit 0 at address 4 clears the status. Writing 0 there leaves it unchanged.
- R9: Writing 1 to bit 0 at address 5 sets the status. Address 5 always reads 0.
- R10: A write to address 3 loads bit 0 of the written value into the status. Reads of address 3 and address 4 return the status in bit 0.
- R11: A count write while the timer runs restarts the timing. The wake follows the R3 formula counted from that write edge, using the new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 3 | Register read address (combinational read) |
| rdData | output | 32 | Register read data |
| irqWake | output | 1 | Wake interrupt, equal to the sticky status |

## Verification
The timing formula is tried with random triples of prescale, start count and threshold. These separate an off-by-one in the prescale divisor from one in the count span. They also separate a late or early pipeline stage, because both the last quiet edge and the first raised edge are checked. Start counts above the threshold exercise the immediate case. The prescale value 0 exercises the counter stepping on every clock. A count rewrite in mid-run shows whether the prescale phase restarts. Status writes of 0 and 1 to each control address show which writes the status responds to and which it ignores.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
  parameter int CNT_W  = 32;
  parameter int PRE_W  = 12;
  parameter int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL   = 3'd0,
    ADR_COUNT  = 3'd1,
    ADR_THRESH = 3'd2,
    ADR_CAUSE  = 3'd3,
    ADR_ISTATE = 3'd4,
    ADR_ITEST  = 3'd5
  } regAddr_e;

  // strobes from the register side to the counting datapath
  typedef struct packed {
    logic             loadCount;
    logic             restart;
    logic [CNT_W-1:0] loadVal;
  } ctlStrobe_t;
endpackage

// File: rtl/wkt_count.sv
module wkt_count
  import wkt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobes,
  input  logic             cfgEnable,
  input  logic [PRE_W-1:0] cfgPrescale,
  input  logic [CNT_W-1:0] cfgThreshold,
  output logic [CNT_W-1:0] count,
  output logic             wakeHit
);
  logic             enS;
  logic [PRE_W-1:0] preS;
  logic [CNT_W-1:0] thrS;
  logic [PRE_W-1:0] preCnt;

  // second stage: configuration copied from the register side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enS  <= 1'b0;
      preS <= '0;
      thrS <= '0;
    end else begin
      enS  <= cfgEnable;
      preS <= cfgPrescale;
      thrS <= cfgThreshold;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      preCnt <= '0;
    end else begin
      if (strobes.loadCount) count <= strobes.loadVal;
      if (strobes.restart || !enS) begin
        preCnt <= '0;
      end else if (preCnt == preS) begin
        preCnt <= '0;
        count  <= count + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  assign wakeHit = enS && (count > thrS);

  // R6
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enS && !strobes.loadCount) |=> $stable(count));
  // R5
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enS && !strobes.restart) |=> (count == $past(count) || count == $past(count) + 1'b1));
  // R5
  pre_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= preS);
endmodule

// File: rtl/wkt_regs.sv
module wkt_regs
  import wkt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  input  logic [CNT_W-1:0]  liveCount,
  input  logic              wakeHit,
  output ctlStrobe_t        strobes,
  output logic              cfgEnable,
  output logic [PRE_W-1:0]  cfgPrescale,
  output logic [CNT_W-1:0]  cfgThreshold,
  output logic              irqStat
);
  logic wrCtrl, wrCount, wrThr, wrCause, wrIst, wrTest;
  logic statNext;

  assign wrCtrl  = wrEn && (wrAddr == ADR_CTRL);
  assign wrCount = wrEn && (wrAddr == ADR_COUNT);
  assign wrThr   = wrEn && (wrAddr == ADR_THRESH);
  assign wrCause = wrEn && (wrAddr == ADR_CAUSE);
  assign wrIst   = wrEn && (wrAddr == ADR_ISTATE);
  assign wrTest  = wrEn && (wrAddr == ADR_ITEST);

  // first stage: stored configuration and strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEnable    <= 1'b0;
      cfgPrescale  <= '0;
      cfgThreshold <= '0;
      strobes      <= '0;
    end else begin
      if (wrCtrl) begin
        cfgEnable   <= wrData[0];
        cfgPrescale <= wrData[PRE_W:1];
      end
      if (wrThr) cfgThreshold <= wrData;
      strobes.loadCount <= wrCount;
      strobes.restart   <= wrCtrl || wrCount || wrThr;
      if (wrCount) strobes.loadVal <= wrData;
    end
  end

  // hardware wake has priority over any software status write
  always_comb begin
    statNext = irqStat;
    if (wakeHit)                    statNext = 1'b1;
    else if (wrCause)               statNext = wrData[0];
    else if (wrTest && wrData[0])   statNext = 1'b1;
    else if (wrIst && wrData[0])    statNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqStat <= 1'b0;
    else       irqStat <= statNext;
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADR_CTRL:   rdData[PRE_W:0] = {cfgPrescale, cfgEnable};
      ADR_COUNT:  rdData = liveCount;
      ADR_THRESH: rdData = cfgThreshold;
      ADR_CAUSE,
      ADR_ISTATE: rdData[0] = irqStat;
      default:    rdData = '0;
    endcase
  end

  // R3
  wake_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeHit |=> irqStat);
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrIst && wrData[0] && !wakeHit) |=> !irqStat);
  // R9
  test_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrTest && wrData[0]) |=> irqStat);
  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqStat && !wrIst && !wrCause) |=> irqStat);
  // R10
  cause_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrCause && !wakeHit) |=> (irqStat == $past(wrData[0])));
endmodule

// File: rtl/wakeup_timer.sv
module wakeup_timer
  import wkt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic              irqWake
);
  ctlStrobe_t       strobes;
  logic             cfgEnable;
  logic [PRE_W-1:0] cfgPrescale;
  logic [CNT_W-1:0] cfgThreshold;
  logic [CNT_W-1:0] liveCount;
  logic             wakeHit;
  logic             irqStat;

  wkt_regs u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .liveCount(liveCount), .wakeHit(wakeHit),
    .strobes(strobes), .cfgEnable(cfgEnable), .cfgPrescale(cfgPrescale),
    .cfgThreshold(cfgThreshold), .irqStat(irqStat)
  );

  wkt_count u_count (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgEnable(cfgEnable),
    .cfgPrescale(cfgPrescale), .cfgThreshold(cfgThreshold),
    .count(liveCount), .wakeHit(wakeHit)
  );

  assign irqWake = irqStat;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !irqWake);
endmodule

// File: tb/wakeup_timer_tb.sv
`timescale 1ns/1ps
module wakeup_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        irqWake;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wakeup_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irqWake(irqWake)
  );

  function automatic int wakeDelay(int unsigned c, int unsigned t, int unsigned p);
    if (c > t) return 2;
    return (t - c + 1) * (p + 1) + 2;
  endfunction

  function automatic int unsigned countAt(int unsigned c, int d, int unsigned p);
    if (d < 1) return c;
    return c + (d - 1) / (p + 1);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    rdAddr = a;
    #1 d = rdData;
  endtask

  task automatic quiesce();
    wr(3'd0, 32'h0);
    edges(2);
    wr(3'd4, 32'h1);
  endtask

  task automatic runWake(string tag, int unsigned c, int unsigned t, int unsigned p);
    int dly;
    quiesce();
    wr(3'd1, c);
    wr(3'd2, t);
    dly = wakeDelay(c, t, p);
    wr(3'd0, (p << 1) | 1);
    edges(dly - 1);
    chk({tag, " quiet"}, irqWake, 1'b0);
    edges(1);
    chk({tag, " raised"}, irqWake, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    void'($urandom(32'h5eed_0042));
    edges(3);
    // R1 reset state
    chk("R1 irq", irqWake, 1'b0);
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], v);
      chk("R1 reg", v, 32'h0);
    end
    rstN = 1'b1;
    edges(2);

    // R2 readback
    wr(3'd2, 32'hA5C3_0F1E);
    rd(3'd2, v); chk("R2 threshold", v, 32'hA5C3_0F1E);
    wr(3'd0, 32'h1FFE);
    rd(3'd0, v); chk("R2 ctrl", v, 32'h1FFE);
    wr(3'd1, 32'h0000_1234);
    edges(1);
    rd(3'd1, v); chk("R2 count", v, 32'h1234);

    // R3 directed: prescale 0, equal count and threshold
    runWake("R3 p0 c=t", 7, 7, 0);
    runWake("R3 p3", 0, 4, 3);
    // R4 count above threshold
    runWake("R4 above", 50, 10, 5);
    runWake("R4 above p0", 1, 0, 0);
    // R3 random
    for (int i = 0; i < 24; i++) begin
      int unsigned p, c, t;
      p = $urandom_range(0, 7);
      c = $urandom_range(0, 1000);
      t = c + $urandom_range(0, 18);
      if (i % 6 == 5) t = c - 1 - $urandom_range(0, 5);
      runWake(t >= c ? "R3 random" : "R4 random", c, t, p);
    end

    // R7 sticky after disable
    wr(3'd0, 32'h0);
    edges(20);
    chk("R7 sticky", irqWake, 1'b1);
    // R8 write 0 ignored, write 1 clears
    wr(3'd4, 32'h0);
    chk("R8 zero ignored", irqWake, 1'b1);
    wr(3'd4, 32'h1);
    chk("R8 clear", irqWake, 1'b0);
    rd(3'd4, v); chk("R10 istate read", v, 32'h0);
    // R9 test set
    wr(3'd5, 32'h0);
    chk("R9 zero ignored", irqWake, 1'b0);
    wr(3'd5, 32'h1);
    chk("R9 set", irqWake, 1'b1);
    rd(3'd5, v); chk("R9 reads zero", v, 32'h0);
    // R10 cause loads
    wr(3'd3, 32'h0);
    chk("R10 cause clear", irqWake, 1'b0);
    wr(3'd3, 32'hFFFF_FFFF);
    chk("R10 cause set", irqWake, 1'b1);
    rd(3'd3, v); chk("R10 cause read", v, 32'h1);

    // R5 count progression, R6 hold
    for (int i = 0; i < 6; i++) begin
      int unsigned p, c;
      int d;
      p = (i == 0) ? 0 : $urandom_range(1, 6);
      c = $urandom_range(0, 500);
      d = (i == 1) ? 0 : $urandom_range(1, 60);
      quiesce();
      wr(3'd2, 32'hFFFF_FFFF);
      wr(3'd1, c);
      wr(3'd0, (p << 1) | 1);
      edges(d);
      rd(3'd1, v);
      chk("R5 count", v, countAt(c, d, p));
      wr(3'd0, 32'h0);
      edges(2);
      rd(3'd1, v);
      edges(30);
      rd(3'd1, v2);
      chk("R6 hold", v2, v);
    end

    // R11 count rewrite while running
    quiesce();
    wr(3'd1, 0);
    wr(3'd2, 40);
    wr(3'd0, (3 << 1) | 1);
    edges(25);
    wr(3'd1, 30);
    edges(wakeDelay(30, 40, 3) - 1);
    chk("R11 quiet", irqWake, 1'b0);
    edges(1);
    chk("R11 raised", irqWake, 1'b1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule